// File: doc/BRIEF.md
# SONET A1/A2 Frame Boundary Detector

This block watches a byte-aligned parallel stream, one byte per byte-clock cycle, as produced by an upstream word aligner. It looks for the point where a run of A1 framing bytes gives way to a run of A2 framing bytes. When it finds that boundary it emits a frame pulse one byte-clock wide. The pulse also goes back to the aligner so that the aligner stops hunting.

The match covers a window of consecutive valid bytes. The window holds the last `LEAD_A1` A1 bytes (default two) and then `MATCH_A2` A2 bytes (default one). The pulse is registered. It rises in the cycle after the byte that completes the window. With the defaults, that is one byte period after the first A2 byte is presented.

A build with `MATCH_A2 = 3` requires the full A1, A1, A2, A2, A2 sequence before it pulses. That build pulses one byte period after the third A2 byte. Runs of 3, 12 or 48 bytes of each kind produce exactly one pulse per frame. A low data-valid flag suppresses the pulse and breaks any partial match.

Top module: `frame_boundary_det`

## Requirements
- R1: A synchronous reset holds the frame pulse low and clears the byte history. After reset is released, a bare A2 byte produces no pulse, even if A1 bytes arrived just before the reset.
- R2: The A1 byte is 8'hF6 and the A2 byte is 8'h28. A pulse needs `LEAD_A1` consecutive valid A1 bytes, directly followed by `MATCH_A2` consecutive valid A2 bytes.
- R3: The frame pulse is high for exactly one byte-clock cycle per match.
- R4: The pulse is high in the cycle after the byte that completes the match. With the default `MATCH_A2 = 1`, this is the cycle after the first A2 byte is presented.
- R5: Framing runs of 3, 12 and 48 A1 bytes followed by as many A2 bytes each give exactly one pulse per frame, at the R4 position. A longer A1 or A2 run adds no pulse.
- R6: A single A1 byte directly before the A2 run gives no pulse.
- R7: A byte presented with valid low never produces a pulse, and it breaks the byte history. Matching then restarts from the next valid bytes.
- R8: A byte that differs from A1 or A2 in any single bit does not count as that byte.
- R9: With `MATCH_A2 = 3`, a run of only two A2 bytes gives no pulse. A run of three A2 bytes gives a pulse in the cycle after the third A2 byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Byte clock |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Byte on `byte_i` is valid this cycle |
| byte_i | input | DATA_W | Aligned parallel byte; the first serial bit is the MSB |
| frame_pulse_o | output | 1 | One-cycle frame boundary pulse |

## Verification
Two builds run side by side on every input pattern: the default single-A2 build and the full A1A1A2A2A2 build.

- Clean A1-to-A2 boundaries check the pulse latency of each build.
- A lone A1 shows that two leading A1 bytes are required.
- Single-bit-corrupted A1 and A2 bytes show that the compare is exact.
- A valid-low byte within a run shows that gating clears the history and does not only hide the pulse.
- Back-to-back frames, and frames with runs of 3, 12 and 48 bytes, show that long runs yield exactly one pulse each.
- A short A2 run tells the two builds apart.
- A reset placed between A1 bytes and an A2 byte shows that the history is really cleared.

// File: rtl/frame_det_pkg.sv
package frame_det_pkg;

   localparam int unsigned OCTET_W = 8;
   localparam logic [OCTET_W-1:0] A1_DEFAULT = 8'hF6;
   localparam logic [OCTET_W-1:0] A2_DEFAULT = 8'h28;

   // Number of bytes in the match window, the current byte included
   function automatic int unsigned window_len(int unsigned lead_a1, int unsigned match_a2);
      return lead_a1 + match_a2;
   endfunction

endpackage

// File: rtl/frame_hist_shift.sv
module frame_hist_shift #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 2
) (
   input  logic                        clk_i,
   input  logic                        rst_i,
   input  logic                        valid_i,
   input  logic [WIDTH-1:0]            byte_i,
   output logic [DEPTH-1:0][WIDTH-1:0] hist_o,
   output logic [DEPTH-1:0]            hist_vld_o
);

   // Stage 0 holds the newest byte. A valid-low cycle empties every stage.
   for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      logic [WIDTH-1:0] src_data;
      logic             src_vld;

      if (s == 0) begin : g_head
         assign src_data = byte_i;
         assign src_vld  = 1'b1;
      end else begin : g_tail
         assign src_data = hist_o[s-1];
         assign src_vld  = hist_vld_o[s-1];
      end

      always_ff @(posedge clk_i) begin
         if (rst_i || !valid_i) begin
            hist_o[s]     <= '0;
            hist_vld_o[s] <= 1'b0;
         end else begin
            hist_o[s]     <= src_data;
            hist_vld_o[s] <= src_vld;
         end
      end
   end

endmodule

// File: rtl/frame_pat_cmp.sv
module frame_pat_cmp #(
   parameter int unsigned      WIDTH    = 8,
   parameter int unsigned      LEAD_A1  = 2,
   parameter int unsigned      MATCH_A2 = 1,
   parameter logic [WIDTH-1:0] A1_PAT   = 8'hF6,
   parameter logic [WIDTH-1:0] A2_PAT   = 8'h28,
   parameter int unsigned      HDEPTH   = LEAD_A1 + MATCH_A2 - 1
) (
   input  logic [WIDTH-1:0]             byte_i,
   input  logic [HDEPTH-1:0][WIDTH-1:0] hist_i,
   input  logic [HDEPTH-1:0]            hist_vld_i,
   output logic                         hit_o
);

   localparam int unsigned WLEN = LEAD_A1 + MATCH_A2;

   logic [WLEN-1:0] slot_ok;

   // Slot 0 is the current byte. Slots below MATCH_A2 expect A2; older slots expect A1.
   for (genvar p = 0; p < WLEN; p++) begin : g_slot
      localparam logic [WIDTH-1:0] EXP = (p < MATCH_A2) ? A2_PAT : A1_PAT;
      if (p == 0) begin : g_cur
         assign slot_ok[p] = (byte_i == EXP);
      end else begin : g_old
         assign slot_ok[p] = hist_vld_i[p-1] && (hist_i[p-1] == EXP);
      end
   end

   assign hit_o = &slot_ok;

endmodule

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen (
   input  logic clk_i,
   input  logic rst_i,
   input  logic valid_i,
   input  logic hit_i,
   output logic pulse_o
);

   always_ff @(posedge clk_i) begin
      if (rst_i) pulse_o <= 1'b0;
      else       pulse_o <= valid_i && hit_i;
   end

endmodule

// File: rtl/frame_boundary_det.sv
module frame_boundary_det
   import frame_det_pkg::*;
#(
   parameter int unsigned       DATA_W   = OCTET_W,
   parameter int unsigned       LEAD_A1  = 2,
   parameter int unsigned       MATCH_A2 = 1,
   parameter logic [DATA_W-1:0] A1_PAT   = A1_DEFAULT,
   parameter logic [DATA_W-1:0] A2_PAT   = A2_DEFAULT
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] byte_i,
   output logic              frame_pulse_o
);

   localparam int unsigned WLEN   = window_len(LEAD_A1, MATCH_A2);
   localparam int unsigned HDEPTH = WLEN - 1;

   if (LEAD_A1 < 1 || LEAD_A1 > 4) begin : g_bad_lead
      $error("frame_boundary_det: LEAD_A1 must be 1..4");
   end
   if (MATCH_A2 < 1 || MATCH_A2 > 3) begin : g_bad_match
      $error("frame_boundary_det: MATCH_A2 must be 1..3");
   end
   if (A1_PAT == A2_PAT) begin : g_bad_pat
      $error("frame_boundary_det: A1 and A2 patterns must differ");
   end

   logic [HDEPTH-1:0][DATA_W-1:0] hist;
   logic [HDEPTH-1:0]             hist_vld;
   logic                          hit;

   frame_hist_shift #(
      .WIDTH (DATA_W),
      .DEPTH (HDEPTH)
   ) hist_i (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .valid_i    (valid_i),
      .byte_i     (byte_i),
      .hist_o     (hist),
      .hist_vld_o (hist_vld)
   );

   frame_pat_cmp #(
      .WIDTH    (DATA_W),
      .LEAD_A1  (LEAD_A1),
      .MATCH_A2 (MATCH_A2),
      .A1_PAT   (A1_PAT),
      .A2_PAT   (A2_PAT),
      .HDEPTH   (HDEPTH)
   ) cmp_i (
      .byte_i     (byte_i),
      .hist_i     (hist),
      .hist_vld_i (hist_vld),
      .hit_o      (hit)
   );

   frame_pulse_gen pulse_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .valid_i (valid_i),
      .hit_i   (hit),
      .pulse_o (frame_pulse_o)
   );

endmodule

// File: rtl/frame_boundary_det_chk.sv
module frame_boundary_det_chk #(
   parameter int unsigned       DATA_W   = 8,
   parameter int unsigned       LEAD_A1  = 2,
   parameter int unsigned       MATCH_A2 = 1,
   parameter logic [DATA_W-1:0] A1_PAT   = 8'hF6,
   parameter logic [DATA_W-1:0] A2_PAT   = 8'h28
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              valid_i,
   input logic [DATA_W-1:0] byte_i,
   input logic              frame_pulse_o
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk_i) $past(rst_i) |-> !frame_pulse_o);

   // R3
   pulse_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      frame_pulse_o |=> !frame_pulse_o);

   // R4
   last_is_a2_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      frame_pulse_o |-> ($past(byte_i) == A2_PAT));

   // R2
   oldest_is_a1_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      frame_pulse_o |-> ($past(byte_i, LEAD_A1 + MATCH_A2) == A1_PAT));

   // R7
   valid_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      frame_pulse_o |-> $past(valid_i));

endmodule

bind frame_boundary_det frame_boundary_det_chk #(
   .DATA_W   (DATA_W),
   .LEAD_A1  (LEAD_A1),
   .MATCH_A2 (MATCH_A2),
   .A1_PAT   (A1_PAT),
   .A2_PAT   (A2_PAT)
) chk_i (
   .clk_i         (clk_i),
   .rst_i         (rst_i),
   .valid_i       (valid_i),
   .byte_i        (byte_i),
   .frame_pulse_o (frame_pulse_o)
);

// File: tb/frame_boundary_det_tb_top.sv
module frame_boundary_det_tb_top;

   localparam int unsigned NVEC = 46;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       valid = 1'b0;
   logic [7:0] data = 8'h00;
   logic       pulse_d;
   logic       pulse_f;
   int         n_chk = 0;
   int         n_bad = 0;

   always #10 clk = ~clk;

   // Default build: two A1 then one A2
   frame_boundary_det dut_i (
      .clk_i (clk), .rst_i (rst), .valid_i (valid), .byte_i (data),
      .frame_pulse_o (pulse_d)
   );

   // Full-sequence build: A1 A1 A2 A2 A2
   frame_boundary_det #(.MATCH_A2(3)) dut_full_i (
      .clk_i (clk), .rst_i (rst), .valid_i (valid), .byte_i (data),
      .frame_pulse_o (pulse_f)
   );

   // {valid, byte, pulse expected on default build, on full build, requirement}
   localparam logic [14:0] VEC [0:NVEC-1] = '{
      {1'b1, 8'h00, 1'b0, 1'b0, 4'd2},
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd2},
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd2},
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd2},
      {1'b1, 8'h28, 1'b1, 1'b0, 4'd4},   // R4 after first A2
      {1'b1, 8'h28, 1'b0, 1'b0, 4'd3},
      {1'b1, 8'h28, 1'b0, 1'b1, 4'd9},   // R9 after third A2
      {1'b1, 8'h55, 1'b0, 1'b0, 4'd3},
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd6},   // R6 lone A1
      {1'b1, 8'h28, 1'b0, 1'b0, 4'd6},
      {1'b1, 8'h28, 1'b0, 1'b0, 4'd6},
      {1'b1, 8'h28, 1'b0, 1'b0, 4'd6},
      {1'b1, 8'hF7, 1'b0, 1'b0, 4'd8},   // R8 corrupted A1
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd8},
      {1'b1, 8'h28, 1'b0, 1'b0, 4'd8},
      {1'b1, 8'h28, 1'b0, 1'b0, 4'd8},
      {1'b1, 8'h28, 1'b0, 1'b0, 4'd8},
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd8},   // R8 corrupted A2
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd8},
      {1'b1, 8'h29, 1'b0, 1'b0, 4'd8},
      {1'b1, 8'h28, 1'b0, 1'b0, 4'd8},
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd7},   // R7 invalid A2
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd7},
      {1'b0, 8'h28, 1'b0, 1'b0, 4'd7},
      {1'b1, 8'h28, 1'b0, 1'b0, 4'd7},
      {1'b1, 8'h28, 1'b0, 1'b0, 4'd7},
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd7},   // R7 gap inside the A1 run
      {1'b0, 8'hF6, 1'b0, 1'b0, 4'd7},
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd7},
      {1'b1, 8'h28, 1'b0, 1'b0, 4'd7},
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd9},   // R9 short A2 run
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd9},
      {1'b1, 8'h28, 1'b1, 1'b0, 4'd9},
      {1'b1, 8'h28, 1'b0, 1'b0, 4'd9},
      {1'b1, 8'h00, 1'b0, 1'b0, 4'd9},
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd2},   // R2 back-to-back frames
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd2},
      {1'b1, 8'h28, 1'b1, 1'b0, 4'd2},
      {1'b1, 8'h28, 1'b0, 1'b0, 4'd3},
      {1'b1, 8'h28, 1'b0, 1'b1, 4'd2},
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd3},
      {1'b1, 8'hF6, 1'b0, 1'b0, 4'd2},
      {1'b1, 8'h28, 1'b1, 1'b0, 4'd2},
      {1'b1, 8'h28, 1'b0, 1'b0, 4'd3},
      {1'b1, 8'h28, 1'b0, 1'b1, 4'd2},
      {1'b1, 8'h00, 1'b0, 1'b0, 4'd3}
   };

   task automatic check(input logic exp_d, input logic exp_f, input int req, input string what);
      n_chk++;
      if (pulse_d !== exp_d || pulse_f !== exp_f) begin
         n_bad++;
         $display("FAIL R%0d %s: pulse default=%b full=%b, expected default=%b full=%b",
                  req, what, pulse_d, pulse_f, exp_d, exp_f);
      end
   endtask

   // Drive at the falling edge, sample 5 ns after the rising edge that captures it
   task automatic step(input logic v, input logic [7:0] d, input logic exp_d,
                       input logic exp_f, input int req, input string what);
      @(negedge clk);
      valid = v;
      data  = d;
      @(posedge clk);
      #5;
      check(exp_d, exp_f, req, what);
   endtask

   task automatic run_frame(input int n);
      for (int i = 0; i < 5; i++) step(1'b1, 8'h3C, 1'b0, 1'b0, 5, "filler");
      for (int i = 0; i < n; i++) step(1'b1, 8'hF6, 1'b0, 1'b0, 5, "A1 run");
      for (int i = 0; i < n; i++)
         step(1'b1, 8'h28, (i == 0), (i == 2), 5, "A2 run");
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      check(1'b0, 1'b0, 1, "R1 pulse low in reset");
      @(negedge clk);
      rst = 1'b0;

      for (int k = 0; k < NVEC; k++)
         step(VEC[k][14], VEC[k][13:6], VEC[k][5], VEC[k][4], int'(VEC[k][3:0]), "table");

      // R1: reset between the A1 bytes and the A2 byte clears the history
      step(1'b1, 8'hF6, 1'b0, 1'b0, 1, "A1 before reset");
      step(1'b1, 8'hF6, 1'b0, 1'b0, 1, "A1 before reset");
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #5;
      check(1'b0, 1'b0, 1, "R1 during reset");
      @(negedge clk);
      rst = 1'b0;
      step(1'b1, 8'h28, 1'b0, 1'b0, 1, "R1 A2 after reset");
      step(1'b1, 8'h28, 1'b0, 1'b0, 1, "R1 A2 after reset");
      step(1'b1, 8'h28, 1'b0, 1'b0, 1, "R1 A2 after reset");

      // R5: STS-3, STS-12 and STS-48 run lengths, two frames each
      run_frame(3);
      run_frame(3);
      run_frame(12);
      run_frame(12);
      run_frame(48);
      run_frame(48);
      step(1'b1, 8'h00, 1'b0, 1'b0, 5, "after last frame");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule